// File: doc/BRIEF.md
# Per-Channel Level/Edge Trigger Detector

This block decides when a logic-analyzer capture should start. A parallel word of input channels is presented together with a one-cycle sample strobe. While the detector is armed, each strobed word is tested against a per-channel condition. Each channel is either level-sensitive or edge-sensitive, with a selectable polarity. The edge test compares the strobed word with the word from the previous strobe since arming.

Three configuration words hold one bit per channel: the polarity, the condition kind and an inclusion mask. The trigger fires when every included channel meets its condition on the same strobe. A one-cycle pulse then marks the event, and a sticky flag holds it until the next arm. A two-bit status output reports whether the detector is waiting (bit 0) or has triggered (bit 1).

Top module: `chan_trigger_unit`

## Requirements
- R1: After a synchronous active-low reset, `trig_pulse` is 0, `triggered` is 0 and `status` is 2'b00.
- R2: Strobes presented before the first `arm` have no effect: `triggered` stays 0 even if every condition holds.
- R3: For a channel with mode bit 0 (level), polarity bit 0 is met when the sample bit is 0, and polarity bit 1 is met when the sample bit is 1.
- R4: For a channel with mode bit 1 (edge), polarity bit 1 is met on a 0-to-1 change and polarity bit 0 on a 1-to-0 change, both taken between two consecutive strobes; a change in the opposite direction does not meet it.
- R5: A channel whose mask bit is 0 takes no part in the decision. With an all-zero mask, the first strobe after arming fires the trigger.
- R6: The trigger fires only when every channel whose mask bit is 1 meets its condition on the same strobe.
- R7: On the first strobe after arming there is no earlier sample, so no edge condition is met.
- R8: A strobe that meets the conditions in clock edge k sets `triggered` and `trig_pulse` after edge k. `trig_pulse` lasts exactly one cycle. `status[1]` equals `triggered`, and `status[0]` is 1 while the detector is armed and has not fired.
- R9: `arm` clears `triggered` and starts a new search. A strobe in the same cycle as `arm` is ignored.
- R10: Once triggered, later strobes give no further pulse and leave `triggered` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Starts a new trigger search, clears the flag |
| sample_en | input | 1 | Strobe: `sample_word` is valid this cycle |
| sample_word | input | NUM_CH | Channel values |
| cfg_polarity | input | NUM_CH | Per channel: high/rising (1) or low/falling (0) |
| cfg_edge_mode | input | NUM_CH | Per channel: edge (1) or level (0) |
| cfg_enable | input | NUM_CH | Per channel: included (1) or excluded (0) |
| trig_pulse | output | 1 | One-cycle trigger event |
| triggered | output | 1 | Sticky trigger flag |
| status | output | 2 | bit 1 triggered, bit 0 waiting |

## Verification
The assertions assume the configuration words stay fixed while the detector is armed. They also assume `arm` is not held high across a strobe that should be evaluated. The bench sets up the configuration before each arm, pulses `arm` for one cycle, and changes inputs only on the falling clock edge. The one exception is the deliberate same-cycle arm-and-strobe case, which covers R9.

// File: rtl/trig_pkg.sv
// Package: shared types for the trigger detector.
// Assumes nothing beyond being compiled before its users.
package trig_pkg;
    // Search state of the detector
    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_WAIT  = 2'd1,
        TS_FIRED = 2'd2
    } trig_state_t;
endpackage

// File: rtl/trig_chan_cell.sv
// Module: per-channel condition test.
// Produces "ok" when the channel is excluded by its mask bit or meets its
// level/edge condition. Assumes prev_ok is 0 when no earlier sample exists.
module trig_chan_cell (
    input  logic cur_bit,
    input  logic prev_bit,
    input  logic prev_ok,
    input  logic pol,
    input  logic edge_mode,
    input  logic en,
    output logic ok
);
    logic level_hit;
    logic edge_hit;

    // Evaluate both condition kinds and pick by mode, masking last
    always_comb begin
        level_hit = (cur_bit == pol);
        edge_hit  = prev_ok && (prev_bit != cur_bit) && (cur_bit == pol);
        ok        = !en || (edge_mode ? edge_hit : level_hit);
    end

    // R7: an included edge channel cannot be met without an earlier sample
    always_comb begin
        if (en && edge_mode && !prev_ok)
            a_r7_no_edge_first: assert (!ok || $isunknown(cur_bit));
    end
endmodule

// File: rtl/trig_history.sv
// Module: holds the word from the previous evaluated strobe.
// Validity is dropped on arm so the first strobe after arming sees no edge.
module trig_history #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              eval_en,
    input  logic [NUM_CH-1:0] sample_word,
    output logic [NUM_CH-1:0] prev_word,
    output logic              prev_ok
);
    // Capture the evaluated word and track whether it exists
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_word <= '0;
            prev_ok   <= 1'b0;
        end else if (arm) begin
            prev_ok   <= 1'b0;
        end else if (eval_en) begin
            prev_word <= sample_word;
            prev_ok   <= 1'b1;
        end
    end

    // R7: arming always invalidates the history on the next cycle
    a_r7_arm_clears_history: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !prev_ok);
endmodule

// File: rtl/trig_ctrl.sv
// Module: search state machine, trigger pulse and sticky flag.
// Assumes match_all is valid in any cycle where sample_en is high.
module trig_ctrl
    import trig_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       sample_en,
    input  logic       match_all,
    output logic       eval_en,
    output logic       trig_pulse,
    output logic       triggered,
    output logic [1:0] status
);
    trig_state_t state;

    // A strobe counts only while waiting and not overridden by arm
    always_comb eval_en = (state == TS_WAIT) && sample_en && !arm;

    // Advance the search state and form the one-cycle event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TS_IDLE;
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            if (arm) begin
                state <= TS_WAIT;
            end else if (eval_en && match_all) begin
                state      <= TS_FIRED;
                trig_pulse <= 1'b1;
            end
        end
    end

    // Decode outputs from the state
    always_comb begin
        triggered = (state == TS_FIRED);
        status    = {triggered, state == TS_WAIT};
    end

    // R8: the event pulse lasts one cycle
    a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    // R8: the pulse follows a strobe in the previous cycle
    a_r8_pulse_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_pulse) |-> $past(sample_en));
    // R10: the flag holds until arm
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !arm) |=> triggered);
    // R9: arm clears the flag
    a_r9_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!triggered && status == 2'b01));
    // R2: nothing fires without an arm
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TS_IDLE) |=> !trig_pulse);
endmodule

// File: rtl/chan_trigger_unit.sv
// Module: top of the per-channel level/edge trigger detector.
// Assumes configuration words are stable while armed.
module chan_trigger_unit #(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              sample_en,
    input  logic [NUM_CH-1:0] sample_word,
    input  logic [NUM_CH-1:0] cfg_polarity,
    input  logic [NUM_CH-1:0] cfg_edge_mode,
    input  logic [NUM_CH-1:0] cfg_enable,
    output logic              trig_pulse,
    output logic              triggered,
    output logic [1:0]        status
);
    logic [NUM_CH-1:0] prev_word;
    logic              prev_ok;
    logic [NUM_CH-1:0] chan_ok;
    logic              match_all;
    logic              eval_en;

    trig_history #(.NUM_CH(NUM_CH)) u_hist (
        .clk(clk), .rst_n(rst_n), .arm(arm), .eval_en(eval_en),
        .sample_word(sample_word), .prev_word(prev_word), .prev_ok(prev_ok)
    );

    // One condition cell per channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        trig_chan_cell u_cell (
            .cur_bit(sample_word[g]), .prev_bit(prev_word[g]),
            .prev_ok(prev_ok), .pol(cfg_polarity[g]),
            .edge_mode(cfg_edge_mode[g]), .en(cfg_enable[g]),
            .ok(chan_ok[g])
        );
    end

    // All included channels must agree on the same sample
    always_comb match_all = &chan_ok;

    trig_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .sample_en(sample_en),
        .match_all(match_all), .eval_en(eval_en), .trig_pulse(trig_pulse),
        .triggered(triggered), .status(status)
    );

    // R5: an all-zero mask fires on any evaluated strobe
    a_r5_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_en && cfg_enable == '0) |=> trig_pulse);
endmodule

// File: tb/chan_trigger_unit_test.sv
module chan_trigger_unit_test;
    localparam int NV = 10;
    // Per vector: polarity, mode, mask, two samples, expected flag after each
    localparam logic [31:0] V_POL  [NV] = '{32'h1, 32'h0, 32'h4, 32'h0, 32'h4,
        32'h0, 32'h80000001, 32'h80000001, 32'h1, 32'h0};
    localparam logic [31:0] V_MODE [NV] = '{32'h0, 32'h0, 32'h4, 32'h4, 32'h4,
        32'h0, 32'h80000000, 32'h80000000, 32'h0, 32'h4};
    localparam logic [31:0] V_MASK [NV] = '{32'h1, 32'h1, 32'h4, 32'h4, 32'h4,
        32'h0, 32'h80000001, 32'h80000001, 32'h1, 32'h4};
    localparam logic [31:0] V_S0   [NV] = '{32'h0, 32'h1, 32'h0, 32'h4, 32'h4,
        32'h5, 32'h1, 32'h1, 32'h20, 32'h0};
    localparam logic [31:0] V_S1   [NV] = '{32'h1, 32'h0, 32'h4, 32'h0, 32'h4,
        32'h0, 32'h80000000, 32'h80000001, 32'h21, 32'h4};
    localparam logic V_E0 [NV] = '{0,0,0,0,0,1,0,0,0,0};
    localparam logic V_E1 [NV] = '{1,1,1,1,0,1,0,1,1,0};

    logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, sample_en = 1'b0;
    logic [31:0] sample_word = '0, cfg_polarity = '0, cfg_edge_mode = '0, cfg_enable = '0;
    logic trig_pulse, triggered;
    logic [1:0] status;
    int checks = 0, fails = 0;
    bit done = 0;

    chan_trigger_unit #(.NUM_CH(32)) uut (.*);

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic strobe(input logic [31:0] w);
        @(negedge clk) begin sample_word = w; sample_en = 1'b1; end
        @(negedge clk) sample_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 triggered", triggered, 0);
        chk("R1 pulse", trig_pulse, 0);
        chk("R1 status", status, 2'b00);
        rst_n = 1'b1;
        // R2: strobes before arm do nothing, even with empty mask
        cfg_enable = '0;
        strobe(32'h0);
        chk("R2 not armed", triggered, 0);

        for (int i = 0; i < NV; i++) begin
            cfg_polarity = V_POL[i]; cfg_edge_mode = V_MODE[i]; cfg_enable = V_MASK[i];
            do_arm();
            chk("R8 status waiting", status, 2'b01);
            strobe(V_S0[i]);
            chk("R3 R4 R5 R6 R7 vector s0", triggered, V_E0[i]);
            strobe(V_S1[i]);
            chk("R3 R4 R5 R6 R7 vector s1", triggered, V_E1[i]);
        end

        // R8: pulse timing, status encoding; R10: no re-fire
        cfg_polarity = 32'h1; cfg_edge_mode = 32'h0; cfg_enable = 32'h1;
        do_arm();
        @(negedge clk) begin sample_word = 32'h1; sample_en = 1'b1; end
        @(negedge clk) sample_en = 1'b0;
        chk("R8 pulse high", trig_pulse, 1);
        chk("R8 status fired", status, 2'b10);
        @(negedge clk);
        chk("R8 pulse one cycle", trig_pulse, 0);
        @(negedge clk) begin sample_word = 32'h1; sample_en = 1'b1; end
        @(negedge clk) sample_en = 1'b0;
        chk("R10 no second pulse", trig_pulse, 0);
        chk("R10 still triggered", triggered, 1);

        // R9: arm together with a strobe; the strobe is ignored
        cfg_enable = '0;
        @(negedge clk) begin arm = 1'b1; sample_en = 1'b1; end
        @(negedge clk) begin arm = 1'b0; sample_en = 1'b0; end
        chk("R9 cleared and strobe ignored", triggered, 0);
        strobe(32'h0);
        chk("R9 next strobe fires", triggered, 1);

        // R4: non-strobed word changes do not form an edge
        cfg_polarity = 32'h4; cfg_edge_mode = 32'h4; cfg_enable = 32'h4;
        do_arm();
        strobe(32'h4);
        @(negedge clk) sample_word = 32'h0;
        @(negedge clk);
        strobe(32'h4);
        chk("R4 no edge between strobes", triggered, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule